// File: doc/BRIEF.md
# Product-Term Cluster Steering Allocator

This block sits between a sum-of-products AND plane and a bank of sixteen D flip-flops. It takes eighty product terms, grouped as sixteen clusters of five, and decides which macrocell OR gate each term feeds. Every macrocell normally sums its own cluster. It can also claim clusters from up to two positions above or below it, which builds wide sums for the macrocells that need them. A cluster marked as split hands over only four of its terms to the claiming macrocell. Its lowest term stays with its home macrocell, so that macrocell can still produce a single-term function.

Each macrocell runs in one of two modes. Synchronous mode allows up to 20 summed terms. Asynchronous mode reserves the top two terms of the macrocell's home cluster for its private clock and reset, so those terms never reach any sum, and the limit drops to 18. After the OR gate, each macrocell has an exclusive-OR stage. Its second input is either a fixed polarity bit or the macrocell's own registered output, and the second choice lets a D flip-flop behave as a toggle flip-flop. A configuration error flag is raised when a cluster has more than one claimant or when a macrocell's routed term count goes over its mode limit.

Top module: `pterm_steer_alloc`

## Requirements
- R1: With every macrocell claiming only its home cluster (claim offset 2), synchronous mode and XOR source 0, `d_o[i]` equals the OR of terms `pt_i[5i+4:5i]` XOR `xpol_i[i]`, in the same cycle.
- R2: Claim bit `claim_i[5j+k]` makes macrocell j claim cluster j+k-2. A cluster won by another macrocell adds all five of its terms to that macrocell's sum and nothing to its home macrocell.
- R3: When `split_i[c]` is 1, term 0 of cluster c (`pt_i[5c]`) always feeds home macrocell c. Terms 1 to 4 go to the winning claimant, or to nobody if there is none.
- R4: A cluster that no macrocell claims adds no term to any sum, apart from the term 0 that R3 keeps at home.
- R5: When `async_i[c]` is 1, terms 3 and 4 of cluster c (`pt_i[5c+3]`, `pt_i[5c+4]`) feed no sum, whoever claims the cluster.
- R6: When several macrocells claim one cluster, the lowest-index claimant receives it. `cfg_err_o` is 1 after the next rising clock edge.
- R7: `cfg_err_o` is 1 after the next edge when a macrocell's routed term count is above 20 (synchronous) or above 18 (asynchronous). A count exactly at the limit does not raise it.
- R8: Claim bits that point to a cluster index below 0 or above 15 have no effect on `d_o` or `cfg_err_o`.
- R9: With `xsel_i[i]` = 0, `d_o[i]` is the macrocell sum XOR `xpol_i[i]`.
- R10: With `xsel_i[i]` = 1, `d_o[i]` is the sum XOR `q_o[i]`. `q_o[i]` takes `d_o[i]` at every rising edge, so a sum of 1 toggles `q_o[i]` and a sum of 0 holds it.
- R11: While `rst_n` is low, `q_o` and `cfg_err_o` are 0. After `rst_n` rises, the registers stay in reset through two more rising edges and capture on the third.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pt_i | input | 80 | Product terms; cluster c is bits 5c+4..5c |
| claim_i | input | 80 | Per-macrocell claims; bit 5j+k claims cluster j+k-2 |
| split_i | input | 16 | Per-cluster split: keep term 0 at home |
| async_i | input | 16 | Per-macrocell asynchronous mode |
| xsel_i | input | 16 | XOR second input: 0 polarity bit, 1 own register |
| xpol_i | input | 16 | Fixed polarity bits |
| d_o | output | 16 | Flip-flop D inputs (combinational) |
| q_o | output | 16 | Registered macrocell outputs |
| cfg_err_o | output | 1 | Registered configuration error flag |

## Verification
`d_o` follows the term, steering and XOR inputs combinationally. The bench therefore checks it a quarter period after each input change, before the next rising edge. `q_o` and `cfg_err_o` each pass through one register, so they are checked one time unit after the following rising edge, against the values computed from the inputs held during that cycle. Reset release is counted edge by edge: `q_o` must stay 0 through two edges after `rst_n` rises and show the captured `d_o` after the third.

// File: rtl/ptsa_pkg.sv
package ptsa_pkg;
  localparam int PTSA_NMC         = 16; // macrocells and clusters
  localparam int PTSA_CW          = 5;  // terms per cluster
  localparam int PTSA_SPAN        = 2;  // claim reach each side of home
  localparam int PTSA_SYNC_LIMIT  = 20; // max summed terms, synchronous
  localparam int PTSA_ASYNC_LIMIT = 18; // max summed terms, asynchronous
  localparam int PTSA_RSV         = 2;  // top home terms held back in async mode
endpackage

// File: rtl/ptsa_rst_sync.sv
module ptsa_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= stage_d;
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/ptsa_cluster_arb.sv
// Picks one claimant for a cluster: the lowest candidate slot wins.
module ptsa_cluster_arb #(
  parameter int WIN = 5
) (
  input  logic [WIN-1:0] req_i,
  output logic [WIN-1:0] grant_o,
  output logic           conflict_o
);
  always_comb begin
    grant_o    = req_i & (~req_i + WIN'(1));
    conflict_o = |(req_i & (req_i - WIN'(1)));
  end
endmodule

// File: rtl/ptsa_sum_unit.sv
// Forms one macrocell sum from the clusters in its claim window and counts
// the routed terms against the mode limit.
module ptsa_sum_unit #(
  parameter int CW          = 5,
  parameter int SPAN        = 2,
  parameter int RSV         = 2,
  parameter int SYNC_LIMIT  = 20,
  parameter int ASYNC_LIMIT = 18
) (
  input  logic [(2*SPAN+1)*CW-1:0] pt_win_i,
  input  logic [2*SPAN:0]          gnt_win_i,
  input  logic [2*SPAN:0]          split_win_i,
  input  logic [2*SPAN:0]          async_win_i,
  output logic                     sum_o,
  output logic                     over_o
);
  localparam int WIN  = 2*SPAN + 1;
  localparam int CNTW = $clog2(WIN*CW + 1);

  logic [CNTW-1:0] cnt;
  logic [CNTW-1:0] limit;
  logic            acc;

  always_comb begin
    cnt = '0;
    acc = 1'b0;
    for (int k = 0; k < WIN; k++) begin
      for (int t = 0; t < CW; t++) begin
        logic take;
        take = 1'b0;
        if (!(async_win_i[k] && (t >= CW - RSV))) begin
          if (t == 0 && k == SPAN)
            take = gnt_win_i[k] | split_win_i[k];
          else if (t == 0)
            take = gnt_win_i[k] & ~split_win_i[k];
          else
            take = gnt_win_i[k];
        end
        cnt = cnt + CNTW'(take);
        acc = acc | (take & pt_win_i[k*CW + t]);
      end
    end
  end

  always_comb begin
    limit  = async_win_i[SPAN] ? CNTW'(ASYNC_LIMIT) : CNTW'(SYNC_LIMIT);
    sum_o  = acc;
    over_o = (cnt > limit);
  end
endmodule

// File: rtl/ptsa_xor_cell.sv
module ptsa_xor_cell (
  input  logic clk,
  input  logic rst_sync_n,
  input  logic sum_i,
  input  logic xsel_i,
  input  logic xpol_i,
  output logic d_o,
  output logic q_o
);
  logic q_q;
  logic d_w;

  always_comb begin
    d_w = sum_i ^ (xsel_i ? q_q : xpol_i);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) q_q <= 1'b0;
    else             q_q <= d_w;
  end

  assign d_o = d_w;
  assign q_o = q_q;
endmodule

// File: rtl/pterm_steer_alloc.sv
module pterm_steer_alloc
  import ptsa_pkg::*;
#(
  parameter int NMC         = PTSA_NMC,
  parameter int CW          = PTSA_CW,
  parameter int SPAN        = PTSA_SPAN,
  parameter int SYNC_LIMIT  = PTSA_SYNC_LIMIT,
  parameter int ASYNC_LIMIT = PTSA_ASYNC_LIMIT,
  parameter int RSV         = PTSA_RSV
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NMC*CW-1:0]             pt_i,
  input  logic [NMC*(2*SPAN+1)-1:0]     claim_i,
  input  logic [NMC-1:0]                split_i,
  input  logic [NMC-1:0]                async_i,
  input  logic [NMC-1:0]                xsel_i,
  input  logic [NMC-1:0]                xpol_i,
  output logic [NMC-1:0]                d_o,
  output logic [NMC-1:0]                q_o,
  output logic                          cfg_err_o
);
  localparam int WIN  = 2*SPAN + 1;
  localparam int PADW = SPAN*CW;
  localparam int NPAD = NMC + 2*SPAN;

  logic rst_sync_n;

  ptsa_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // Requests per cluster; slot m is candidate macrocell c+m-SPAN.
  logic [WIN-1:0] req_c   [NMC];
  logic [WIN-1:0] grant_c [NMC];
  logic [NMC-1:0] conflict_v;
  // Grants per macrocell; slot k is cluster i+k-SPAN.
  logic [WIN-1:0] gnt_m   [NMC];
  logic           unused_edge_claims;
  logic           unused_edge_grants;

  always_comb begin : p_req
    for (int c = 0; c < NMC; c++) begin
      for (int m = 0; m < WIN; m++) begin
        req_c[c][m] = 1'b0;
        if ((c + m - SPAN >= 0) && (c + m - SPAN < NMC))
          req_c[c][m] = claim_i[(c + m - SPAN)*WIN + (2*SPAN - m)];
      end
    end
  end

  // Claims aimed past either end of the array reach no cluster.
  always_comb begin : p_edge_claims
    logic fold;
    fold = 1'b0;
    for (int j = 0; j < NMC; j++) begin
      for (int k = 0; k < WIN; k++) begin
        if ((j + k - SPAN < 0) || (j + k - SPAN >= NMC))
          fold = fold ^ claim_i[j*WIN + k];
      end
    end
    unused_edge_claims = fold;
  end

  for (genvar c = 0; c < NMC; c++) begin : g_arb
    ptsa_cluster_arb #(.WIN(WIN)) u_arb (
      .req_i      (req_c[c]),
      .grant_o    (grant_c[c]),
      .conflict_o (conflict_v[c])
    );
  end

  always_comb begin : p_gnt
    logic fold;
    fold = 1'b0;
    for (int i = 0; i < NMC; i++) gnt_m[i] = '0;
    for (int c = 0; c < NMC; c++) begin
      for (int m = 0; m < WIN; m++) begin
        if ((c + m - SPAN >= 0) && (c + m - SPAN < NMC))
          gnt_m[c + m - SPAN][2*SPAN - m] = grant_c[c][m];
        else
          fold = fold ^ grant_c[c][m];
      end
    end
    unused_edge_grants = fold;
  end

  // Padding with empty clusters gives every macrocell a full window.
  logic [NPAD*CW-1:0] pt_pad;
  logic [NPAD-1:0]    split_pad;
  logic [NPAD-1:0]    async_pad;

  assign pt_pad    = {{PADW{1'b0}}, pt_i, {PADW{1'b0}}};
  assign split_pad = {{SPAN{1'b0}}, split_i, {SPAN{1'b0}}};
  assign async_pad = {{SPAN{1'b0}}, async_i, {SPAN{1'b0}}};

  logic [NMC-1:0] sum_v;
  logic [NMC-1:0] over_v;

  for (genvar i = 0; i < NMC; i++) begin : g_mc
    ptsa_sum_unit #(
      .CW          (CW),
      .SPAN        (SPAN),
      .RSV         (RSV),
      .SYNC_LIMIT  (SYNC_LIMIT),
      .ASYNC_LIMIT (ASYNC_LIMIT)
    ) u_sum (
      .pt_win_i    (pt_pad[i*CW +: WIN*CW]),
      .gnt_win_i   (gnt_m[i]),
      .split_win_i (split_pad[i +: WIN]),
      .async_win_i (async_pad[i +: WIN]),
      .sum_o       (sum_v[i]),
      .over_o      (over_v[i])
    );

    ptsa_xor_cell u_xor (
      .clk        (clk),
      .rst_sync_n (rst_sync_n),
      .sum_i      (sum_v[i]),
      .xsel_i     (xsel_i[i]),
      .xpol_i     (xpol_i[i]),
      .d_o        (d_o[i]),
      .q_o        (q_o[i])
    );
  end

  logic err_q;
  logic err_d;

  always_comb begin
    err_d = (|conflict_v) | (|over_v);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) err_q <= 1'b0;
    else             err_q <= err_d;
  end

  assign cfg_err_o = err_q;
endmodule

// File: rtl/ptsa_checker.sv
module ptsa_checker #(
  parameter int NMC  = 16,
  parameter int CW   = 5,
  parameter int SPAN = 2
) (
  input logic                      clk,
  input logic                      rst_sync_n,
  input logic [NMC*CW-1:0]         pt_i,
  input logic [NMC*(2*SPAN+1)-1:0] claim_i,
  input logic [NMC-1:0]            async_i,
  input logic [NMC-1:0]            xsel_i,
  input logic [NMC-1:0]            xpol_i,
  input logic [NMC-1:0]            d_o,
  input logic [NMC-1:0]            q_o,
  input logic                      cfg_err_o
);
  localparam int WIN = 2*SPAN + 1;

  logic [NMC*WIN-1:0] home_pat;
  logic [NMC-1:0]     cl_or;
  logic [NMC-1:0]     multi;

  always_comb begin
    home_pat = '0;
    for (int j = 0; j < NMC; j++) home_pat[j*WIN + SPAN] = 1'b1;
  end

  always_comb begin
    for (int c = 0; c < NMC; c++) cl_or[c] = |pt_i[c*CW +: CW];
  end

  always_comb begin
    for (int c = 0; c < NMC; c++) begin
      int n;
      n = 0;
      for (int j = 0; j < NMC; j++)
        for (int k = 0; k < WIN; k++)
          if (j + k - SPAN == c) n = n + int'(claim_i[j*WIN + k]);
      multi[c] = (n > 1);
    end
  end

  assert_home_only_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (claim_i == home_pat && async_i == '0 && xsel_i == '0) |-> (d_o == (cl_or ^ xpol_i)))
    else $error("home-only sum mismatch");

  assert_idle_polarity_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pt_i == '0) |-> (((d_o ^ xpol_i) & ~xsel_i) == '0))
    else $error("idle output differs from polarity");

  assert_conflict_flag_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (|multi) |=> cfg_err_o)
    else $error("shared cluster not flagged");

  assert_q_tracks_d_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rst_sync_n |=> (q_o == $past(d_o)))
    else $error("register did not capture D");

  assert_reset_clear_R11: assert property (@(posedge clk)
    !rst_sync_n |-> (q_o == '0 && !cfg_err_o))
    else $error("state not cleared in reset");
endmodule

bind pterm_steer_alloc ptsa_checker #(.NMC(NMC), .CW(CW), .SPAN(SPAN)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .pt_i       (pt_i),
  .claim_i    (claim_i),
  .async_i    (async_i),
  .xsel_i     (xsel_i),
  .xpol_i     (xpol_i),
  .d_o        (d_o),
  .q_o        (q_o),
  .cfg_err_o  (cfg_err_o)
);

// File: tb/pterm_steer_alloc_tb.sv
module pterm_steer_alloc_tb_top;
  localparam int PER = 10;
  localparam int NMC = 16;
  localparam int CW  = 5;
  localparam int WIN = 5;
  localparam int NPT = NMC*CW;

  logic            clk;
  logic            rst_n;
  logic [NPT-1:0]  pt;
  logic [NMC*WIN-1:0] claim;
  logic [NMC-1:0]  split, asy, xsel, xpol;
  logic [NMC-1:0]  d_w, q_w;
  logic            err_w;

  int checks;
  int failures;
  bit done;
  logic [NMC-1:0] q_model;

  pterm_steer_alloc dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .pt_i      (pt),
    .claim_i   (claim),
    .split_i   (split),
    .async_i   (asy),
    .xsel_i    (xsel),
    .xpol_i    (xpol),
    .d_o       (d_w),
    .q_o       (q_w),
    .cfg_err_o (err_w)
  );

  initial clk = 1'b0;
  always #(PER/2) clk = ~clk;

  task automatic check(input logic [31:0] act, input logic [31:0] exp,
                       input string tag, input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s act=%h exp=%h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic logic [NMC*WIN-1:0] home_cfg();
    logic [NMC*WIN-1:0] v;
    v = '0;
    for (int j = 0; j < NMC; j++) v[j*WIN + 2] = 1'b1;
    return v;
  endfunction

  // Reference: decide each term's destination, then OR and count.
  task automatic model(output logic [NMC-1:0] de, output logic ee);
    int cnt [NMC];
    logic [NMC-1:0] sm;
    logic conf;
    sm = '0;
    conf = 1'b0;
    for (int i = 0; i < NMC; i++) cnt[i] = 0;
    for (int c = 0; c < NMC; c++) begin
      int w;
      int n;
      w = -1;
      n = 0;
      for (int j = 0; j < NMC; j++)
        for (int k = 0; k < WIN; k++)
          if (j + k - 2 == c && claim[j*WIN + k]) begin
            n++;
            if (w < 0) w = j;
          end
      if (n > 1) conf = 1'b1;
      for (int t = 0; t < CW; t++) begin
        int dest;
        if (asy[c] && t >= 3) continue;
        dest = (t == 0 && split[c]) ? c : w;
        if (dest >= 0) begin
          cnt[dest]++;
          if (pt[c*CW + t]) sm[dest] = 1'b1;
        end
      end
    end
    ee = conf;
    for (int i = 0; i < NMC; i++)
      if (cnt[i] > (asy[i] ? 18 : 20)) ee = 1'b1;
    de = sm ^ ((xsel & q_model) | (~xsel & xpol));
  endtask

  // Called at a falling edge with inputs already set.
  task automatic apply(input string tag);
    logic [NMC-1:0] de;
    logic ee;
    #(PER/4);
    model(de, ee);
    check(32'(d_w), 32'(de), tag, "d_o");
    @(posedge clk);
    q_model = de;
    #1;
    check(32'(q_w), 32'(q_model), tag, "q_o");
    check(32'(err_w), 32'(ee), tag, "cfg_err_o");
    @(negedge clk);
  endtask

  task automatic sweep(input string tag);
    pt = '0;
    apply(tag);
    for (int p = 0; p < NPT; p++) begin
      pt = '0;
      pt[p] = 1'b1;
      apply(tag);
    end
    pt = '1;
    apply(tag);
  endtask

  initial begin
    #(PER*150000);
    if (!done) begin
      failures++;
      $display("FAIL R11 watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    checks = 0; failures = 0; done = 1'b0;
    rst_n = 1'b0; pt = '0; claim = home_cfg(); split = '0; asy = '0;
    xsel = '0; xpol = '0; q_model = '0;

    // R11: reset state and synchronous release
    repeat (3) @(negedge clk);
    check(32'(q_w), 0, "R11", "q_o in reset");
    check(32'(err_w), 0, "R11", "cfg_err_o in reset");
    pt = '0; pt[0] = 1'b1;
    #1;
    check(32'(d_w), 32'h1, "R1", "d_o during reset");
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check(32'(q_w), 0, "R11", "q_o edge 1 after release");
    @(posedge clk); #1;
    check(32'(q_w), 0, "R11", "q_o edge 2 after release");
    @(posedge clk); #1;
    check(32'(q_w), 32'h1, "R11", "q_o edge 3 after release");
    q_model = 16'h0001;
    @(negedge clk);

    // R1: home-only, synchronous
    sweep("R1");

    // R9: fixed polarity
    xpol = 16'hA5C3;
    sweep("R9");
    xpol = '0;

    // R2: whole clusters steered to neighbours
    claim = home_cfg();
    claim[2*WIN + 2] = 1'b0; claim[4*WIN + 2] = 1'b0; claim[12*WIN + 2] = 1'b0;
    claim[3*WIN + 3] = 1'b1; claim[3*WIN + 1] = 1'b1; claim[10*WIN + 4] = 1'b1;
    sweep("R2");

    // R3: split clusters keep term 0 at home
    split = '0; split[2] = 1'b1; split[4] = 1'b1; split[12] = 1'b1;
    sweep("R3");

    // R5: asynchronous mode with the same steering
    asy = '1;
    sweep("R5");
    asy = '0; split = '0;

    // R4: unclaimed clusters, one of them split
    claim = home_cfg();
    claim[7*WIN + 2] = 1'b0; claim[9*WIN + 2] = 1'b0;
    split[9] = 1'b1;
    sweep("R4");
    split = '0;

    // R8: claims past the array ends
    claim = home_cfg();
    claim[0*WIN + 0] = 1'b1; claim[0*WIN + 1] = 1'b1;
    claim[1*WIN + 0] = 1'b1;
    claim[15*WIN + 3] = 1'b1; claim[15*WIN + 4] = 1'b1;
    claim[14*WIN + 4] = 1'b1;
    sweep("R8");

    // R6: three claimants of cluster 5, lowest index wins
    claim = home_cfg();
    claim[4*WIN + 3] = 1'b1; claim[6*WIN + 1] = 1'b1;
    sweep("R6");

    // R7: term count against mode limits at macrocell 7
    claim = home_cfg();
    for (int c = 5; c <= 9; c++) claim[c*WIN + 2] = 1'b0;
    for (int k = 0; k < WIN; k++) claim[7*WIN + k] = 1'b1;
    sweep("R7");                       // 25 > 20
    claim[7*WIN + 4] = 1'b0; claim[9*WIN + 2] = 1'b1;
    sweep("R7");                       // 20, at limit
    claim[7*WIN + 4] = 1'b1; claim[9*WIN + 2] = 1'b0;
    split[5] = 1'b1; split[6] = 1'b1; split[8] = 1'b1; split[9] = 1'b1;
    sweep("R7");                       // 21 > 20
    split = '0;
    asy[7] = 1'b1;
    claim[7*WIN + 4] = 1'b0; claim[9*WIN + 2] = 1'b1;
    sweep("R7");                       // 18, async limit
    claim[7*WIN + 4] = 1'b1; claim[9*WIN + 2] = 1'b0;
    sweep("R7");                       // 23 > 18
    for (int c = 5; c <= 9; c++) asy[c] = 1'b1;
    sweep("R5");                       // 15, neighbours hold back terms
    asy = '0;

    // R10: toggle emulation on macrocells 0 and 1
    claim = home_cfg();
    xsel = 16'h0003;
    pt = '0; pt[0] = 1'b1;
    repeat (4) apply("R10");
    pt = '0;
    repeat (3) apply("R10");
    pt[6] = 1'b1;
    repeat (3) apply("R10");
    xsel = '0;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule